// File: doc/BRIEF.md
# Push-Button LED Mode Sequencer

This block drives a single LED from a mechanical push-button and a slide switch. The raw button is synchronized and filtered so that contact bounce is never taken as a press. Each clean press (the moment the filtered level rises) moves a three-state machine forward: dark, flashing, steadily lit, then dark again. The flashing mode has a guard. A press leaves it only when the slide switch reads low at that moment. With the switch high, presses keep the LED flashing.

The flash rate comes from a prescaler counter. The counter restarts every time the flashing mode is entered, so the first lit phase always has full length. The current state is shown on a two-bit debug output. The LED output and the state output are both registered.

Top module: `led_mode_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, the state code is 0 (dark) and the LED is off.
- R2: A press in state 0 moves the machine to state code 1 (flashing).
- R3: A press in state 1 moves the machine to state code 2 (steady) only if the synchronized switch is low when the press is recognized. With the switch high, the machine stays in state 1.
- R4: In state 2 the LED stays lit in every cycle until the next press.
- R5: A press in state 2 returns the machine to state code 0, and the LED turns off the next cycle.
- R6: The button level is accepted only after the synchronized input has differed from the filtered level for DEBOUNCE_CYCLES consecutive cycles. A raw pulse shorter than that has no effect. A raw rising edge changes the state code exactly DEBOUNCE_CYCLES+3 clock edges later.
- R7: A press is recognized only on the filtered rising edge. Holding the button advances the state once, and releasing it does not advance the state.
- R8: In state 1 the LED is lit from the cycle after entry. It then alternates between lit and dark every BLINK_HALF cycles. The prescaler restarts on each entry, so the first lit run is exactly BLINK_HALF cycles.
- R9: The state code is never 3, and it changes only along 0→1, 1→2 and 2→0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_raw | input | 1 | Unfiltered push-button level, high when pressed |
| sw_raw | input | 1 | Unsynchronized slide-switch level |
| led | output | 1 | LED drive, high = lit |
| state_code | output | 2 | Debug state: 0 dark, 1 flashing, 2 steady |

## Verification
A raw button edge takes two synchronizer cycles, then DEBOUNCE_CYCLES filter cycles, then one FSM edge. The state code therefore moves DEBOUNCE_CYCLES+3 edges after the raw edge. The LED follows one edge after the state. One directed test samples the state code one cycle before and exactly at that edge. The table-driven presses hold the button for several cycles beyond the filter window and only then check the settled state, with the switch set a few cycles before each press. Flash timing is measured by counting whole negedge-sampled cycles of each LED run after re-entry into flashing.

// File: rtl/lmc_pkg.sv
package lmc_pkg;
  typedef enum logic [1:0] {
    ST_DARK   = 2'd0,
    ST_FLASH  = 2'd1,
    ST_STEADY = 2'd2
  } lmc_state_e;
endpackage

// File: rtl/lmc_sync.sv
module lmc_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lmc_debounce.sv
module lmc_debounce #(
  parameter int STABLE_CYCLES = 65536
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise
);
  localparam int CW = $clog2(STABLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      level <= 1'b0;
      rise  <= 1'b0;
    end else begin
      rise <= 1'b0;
      if (din != level) begin
        if (cnt == LAST) begin
          level <= din;
          rise  <= din;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/lmc_blink.sv
module lmc_blink #(
  parameter int HALF_PERIOD = 4000000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic phase
);
  localparam int PW = $clog2(HALF_PERIOD + 1);
  localparam logic [PW-1:0] LAST = PW'(HALF_PERIOD - 1);

  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (restart) begin
      cnt   <= '0;
      phase <= 1'b1;
    end else if (run) begin
      if (cnt == LAST) begin
        cnt   <= '0;
        phase <= ~phase;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/led_mode_ctrl.sv
module led_mode_ctrl
  import lmc_pkg::*;
#(
  parameter int DEBOUNCE_CYCLES = 65536,
  parameter int BLINK_HALF      = 4000000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       btn_raw,
  input  logic       sw_raw,
  output logic       led,
  output logic [1:0] state_code
);
  logic [1:0] raw_in, sync_out;
  logic       btn_s, sw_s;
  logic       btn_level, press;
  logic       phase;
  lmc_state_e state_q, state_d;
  logic       enter_flash;

  assign raw_in = {sw_raw, btn_raw};

  lmc_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(sync_out)
  );

  assign btn_s = sync_out[0];
  assign sw_s  = sync_out[1];

  lmc_debounce #(.STABLE_CYCLES(DEBOUNCE_CYCLES)) u_deb (
    .clk(clk), .rst(rst), .din(btn_s), .level(btn_level), .rise(press)
  );

  always_comb begin
    state_d = state_q;
    if (press) begin
      case (state_q)
        ST_DARK:   state_d = ST_FLASH;
        ST_FLASH:  state_d = sw_s ? ST_FLASH : ST_STEADY;
        ST_STEADY: state_d = ST_DARK;
        default:   state_d = ST_DARK;
      endcase
    end
  end

  assign enter_flash = press && (state_q == ST_DARK);

  lmc_blink #(.HALF_PERIOD(BLINK_HALF)) u_blink (
    .clk(clk), .rst(rst), .restart(enter_flash),
    .run(state_q == ST_FLASH), .phase(phase)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_DARK;
      led     <= 1'b0;
    end else begin
      state_q <= state_d;
      led     <= (state_q == ST_STEADY) || ((state_q == ST_FLASH) && phase);
    end
  end

  assign state_code = state_q;
endmodule

// File: rtl/lmc_checker.sv
module lmc_checker
  import lmc_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       led,
  input logic [1:0] state_code,
  input logic       press,
  input logic       sw_s
);
  AST_RESET_DARK: assert property (@(posedge clk)
    rst |=> (state_code == ST_DARK && !led)); // R1

  AST_NO_CODE3: assert property (@(posedge clk) disable iff (rst)
    state_code != 2'd3); // R9

  AST_ENTER_FLASH: assert property (@(posedge clk) disable iff (rst)
    (state_code == ST_FLASH && $past(state_code) != ST_FLASH) |-> $past(state_code) == ST_DARK); // R2

  AST_ENTER_STEADY: assert property (@(posedge clk) disable iff (rst)
    (state_code == ST_STEADY && $past(state_code) != ST_STEADY) |->
      ($past(state_code) == ST_FLASH && !$past(sw_s))); // R3

  AST_STEADY_LIT: assert property (@(posedge clk) disable iff (rst)
    state_code == ST_STEADY |=> led); // R4

  AST_DARK_OFF: assert property (@(posedge clk) disable iff (rst)
    state_code == ST_DARK |=> !led); // R5

  AST_HOLD_WITHOUT_PRESS: assert property (@(posedge clk) disable iff (rst)
    !press |=> $stable(state_code)); // R6

  AST_SINGLE_PRESS: assert property (@(posedge clk) disable iff (rst)
    press |=> !press); // R7
endmodule

bind led_mode_ctrl lmc_checker u_chk (
  .clk(clk), .rst(rst), .led(led), .state_code(state_code),
  .press(press), .sw_s(sw_s)
);

// File: tb/sim_led_mode_ctrl.sv
module sim_led_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DEB  = 4;
  localparam int HALF = 8;
  localparam int NSTEP = 7;
  // each entry: {switch level during press, expected state code after press}
  localparam logic [2:0] STEPS [NSTEP] = '{
    {1'b1, 2'd1}, {1'b1, 2'd1}, {1'b0, 2'd2}, {1'b1, 2'd0},
    {1'b0, 2'd1}, {1'b0, 2'd2}, {1'b0, 2'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn_raw = 1'b0;
  logic sw_raw = 1'b0;
  logic led;
  logic [1:0] state_code;
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  led_mode_ctrl #(.DEBOUNCE_CYCLES(DEB), .BLINK_HALF(HALF)) u0 (
    .clk(clk), .rst(rst), .btn_raw(btn_raw), .sw_raw(sw_raw),
    .led(led), .state_code(state_code)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic press_release();
    btn_raw = 1'b1;
    repeat (DEB + 8) @(negedge clk);
    btn_raw = 1'b0;
    repeat (DEB + 8) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int run;
    repeat (3) @(negedge clk);
    check("R1 state in reset", state_code, 0);
    check("R1 led in reset", led, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 state after reset", state_code, 0);
    check("R1 led after reset", led, 0);

    // R6: short glitch ignored
    btn_raw = 1'b1;
    repeat (DEB - 1) @(negedge clk);
    btn_raw = 1'b0;
    repeat (DEB + 6) @(negedge clk);
    check("R6 glitch ignored", state_code, 0);

    // table walk: R2 R3 R4 R5 R7
    for (int i = 0; i < NSTEP; i++) begin
      sw_raw = STEPS[i][2];
      repeat (4) @(negedge clk);
      press_release();
      check($sformatf("R2/R3/R5/R7 step %0d state", i), state_code, int'(STEPS[i][1:0]));
      if (STEPS[i][1:0] == 2'd2) begin
        run = 0;
        for (int k = 0; k < 3 * HALF; k++) begin
          @(negedge clk);
          if (led) run++;
        end
        check($sformatf("R4 step %0d steady lit cycles", i), run, 3 * HALF);
      end
      if (STEPS[i][1:0] == 2'd0) check($sformatf("R5 step %0d led off", i), led, 0);
    end

    // R6 exact latency and R8 flash timing on re-entry
    sw_raw = 1'b1;
    repeat (4) @(negedge clk);
    btn_raw = 1'b1;
    repeat (DEB + 2) @(negedge clk);
    check("R6 state one edge before latency", state_code, 0);
    @(negedge clk);
    check("R6 state at latency", state_code, 1);
    check("R8 led dark at entry edge", led, 0);
    @(negedge clk);
    check("R8 led lit cycle after entry", led, 1);
    run = 0;
    while (led && run < 4 * HALF) begin
      run++;
      @(negedge clk);
    end
    check("R8 first lit run", run, HALF);
    run = 0;
    while (!led && run < 4 * HALF) begin
      run++;
      @(negedge clk);
    end
    check("R8 dark run", run, HALF);
    // still held: R7 single advance
    repeat (3 * HALF) @(negedge clk);
    check("R7 hold advances once", state_code, 1);
    btn_raw = 1'b0;
    repeat (DEB + 8) @(negedge clk);
    check("R7 release no advance", state_code, 1);

    // leave flashing mid-phase, return to dark, re-enter: R8 restart
    sw_raw = 1'b0;
    repeat (HALF / 2) @(negedge clk);
    press_release();
    check("R3 leave flash switch low", state_code, 2);
    press_release();
    check("R5 back to dark", state_code, 0);
    btn_raw = 1'b1;
    repeat (DEB + 4) @(negedge clk);
    check("R2 re-entry flash", state_code, 1);
    run = 0;
    while (led && run < 4 * HALF) begin
      run++;
      @(negedge clk);
    end
    check("R8 restart full lit run", run, HALF);
    btn_raw = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule